// File: doc/BRIEF.md
# Program-Memory Download and Verify Sequencer

This block loads a byte image into the program memory of an embedded processor, checks the copy, and then lets the processor run. It reaches that memory only through three indirect registers, all in one register block and subblock: a control register, an address pointer and a data port. The pointer advances on its own after every data-port access. The block sends 32-bit register requests to an external register-access engine, such as a serial master, one request at a time. It takes the image bytes from a synchronous byte ROM that returns data one cycle after the address.

One pulse on the start input runs a fixed sequence. The processor is halted and the pointer is set to zero. The image is written one byte per data-port write. The pointer is set to zero again and every byte is read back and compared. If all bytes match, the control register receives the run pattern. At the end the block pulses done and holds an error flag and a mismatch count until the next run.

Top module: `mcl_seq`

## Requirements
- R1: After reset, done_o, error_o and req_valid_o are 0 and mismatch_o is 0.
- R2: The first request of a run is a write (req_write_o=1) to block 7, subblock 0, register 0x10, with data 0x0000008C.
- R3: The second request is a write to register 0x11 with data 0.
- R4: For each image index i from 0 to image_len_i-1, in order, a write to register 0x12 carries {24'b0, image byte i}.
- R5: After the last image write, a write of 0 to register 0x11 follows, then one read (req_write_o=0) of register 0x12 per image byte, in index order.
- R6: A read response above 0xFF ends the run at once with error_o=1. The mismatch count is not changed and no further request is issued.
- R7: A read whose low byte differs from the image byte increments mismatch_o. When the count reaches 5, no further read is issued and the run ends with error_o=1.
- R8: If the readback finishes with a mismatch count of 1 to 4, the run ends with error_o=1 and the run-pattern write is not issued.
- R9: If every byte matches, a write of 0x0000010B to register 0x10 is the last request, and the run ends with error_o=0.
- R10: A response with rsp_err_i=1 ends the run with error_o=1 and no further request.
- R11: done_o is high for exactly one cycle, in the cycle after the final response is accepted. A start pulse during a run has no effect on the request sequence.
- R12: With image_len_i=0 the run issues only the halt write, the two pointer writes and the run-pattern write, and ends with error_o=0.
- R13: A request is held, with valid and fields stable, until a response arrives. It is accepted on the clock edge where rsp_valid_i is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start pulse, taken only when idle |
| image_len_i | input | AW+1 | Image length in bytes, latched at start |
| rom_addr_o | output | AW | Image ROM byte address |
| rom_data_i | input | 8 | Image ROM data, one cycle after the address |
| req_valid_o | output | 1 | Register request outstanding |
| req_write_o | output | 1 | 1 = write, 0 = read |
| req_block_o | output | 3 | Target register block |
| req_sub_o | output | 4 | Target subblock |
| req_reg_o | output | 8 | Target register number |
| req_wdata_o | output | 32 | Write data (0 for reads) |
| rsp_valid_i | input | 1 | Response for the outstanding request |
| rsp_err_i | input | 1 | Transport error on that access |
| rsp_rdata_i | input | 32 | Read data |
| done_o | output | 1 | One-cycle end-of-run pulse |
| error_o | output | 1 | Run failed, held until next start |
| mismatch_o | output | CW | Readback mismatch count, held until next start |

## Verification
Every run produces one result, the done pulse with its error flag and mismatch count, and that result is due in the cycle after the final response is accepted. The bench responder records the cycle of the response that its own model expects to be last. On every falling edge it checks that done_o is high exactly one cycle later and low in every other cycle. Each request is checked against the model's expected list in the cycle the responder answers it, and the responder varies its answer delay from 0 to 2 cycles. The error and count outputs are read in the done cycle. The bench checks one cycle later that done_o has dropped and that no further request has appeared.

// File: rtl/mcl_pkg.sv
package mcl_pkg;
  localparam logic [31:0] HALT_PAT = 32'h0000_008C;  // hold reset, boot, external access
  localparam logic [31:0] RUN_PAT  = 32'h0000_010B;  // clk div, boot, clk enable, soft reset

  typedef enum logic [3:0] {
    S_IDLE, S_HALT, S_PTR_A, S_WFETCH, S_WLOAD, S_WDATA,
    S_PTR_B, S_RFETCH, S_RLOAD, S_RDATA, S_RUN
  } seq_state_t;
endpackage

// File: rtl/mcl_req_port.sv
module mcl_req_port #(
  parameter int RW = 8,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load_i,
  input  logic          write_i,
  input  logic [RW-1:0] reg_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          rsp_valid_i,
  output logic          valid_o,
  output logic          write_o,
  output logic [RW-1:0] reg_o,
  output logic [DW-1:0] wdata_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      valid_o <= 1'b0;
      write_o <= 1'b0;
      reg_o   <= '0;
      wdata_o <= '0;
    end else if (load_i) begin
      valid_o <= 1'b1;
      write_o <= write_i;
      reg_o   <= reg_i;
      wdata_o <= write_i ? wdata_i : '0;
    end else if (rsp_valid_i && valid_o) begin
      valid_o <= 1'b0;
    end
  end
endmodule

// File: rtl/mcl_verify.sv
module mcl_verify #(
  parameter int MM_LIMIT = 4,
  parameter int DW       = 32,
  localparam int CW      = $clog2(MM_LIMIT + 2)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr_i,
  input  logic          chk_i,
  input  logic [DW-1:0] rdata_i,
  input  logic [7:0]    exp_i,
  output logic          over_o,
  output logic          diff_o,
  output logic          abort_o,
  output logic [CW-1:0] count_o
);
  assign over_o  = |rdata_i[DW-1:8];
  assign diff_o  = rdata_i[7:0] != exp_i;
  assign abort_o = chk_i && !over_o && diff_o && (count_o == CW'(MM_LIMIT));

  always_ff @(posedge clk) begin
    if (rst || clr_i)
      count_o <= '0;
    else if (chk_i && !over_o && diff_o)
      count_o <= count_o + 1'b1;
  end
endmodule

// File: rtl/mcl_seq.sv
module mcl_seq
  import mcl_pkg::*;
#(
  parameter int          AW       = 10,
  parameter int          MM_LIMIT = 4,
  parameter logic [2:0]  BLK      = 3'd7,
  parameter logic [3:0]  SUB      = 4'd0,
  parameter logic [7:0]  CTRL_REG = 8'h10,
  parameter logic [7:0]  PTR_REG  = 8'h11,
  parameter logic [7:0]  DATA_REG = 8'h12,
  localparam int         CW       = $clog2(MM_LIMIT + 2)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start_i,
  input  logic [AW:0]   image_len_i,
  output logic [AW-1:0] rom_addr_o,
  input  logic [7:0]    rom_data_i,
  output logic          req_valid_o,
  output logic          req_write_o,
  output logic [2:0]    req_block_o,
  output logic [3:0]    req_sub_o,
  output logic [7:0]    req_reg_o,
  output logic [31:0]   req_wdata_o,
  input  logic          rsp_valid_i,
  input  logic          rsp_err_i,
  input  logic [31:0]   rsp_rdata_i,
  output logic          done_o,
  output logic          error_o,
  output logic [CW-1:0] mismatch_o
);
  seq_state_t    state, nxt;
  logic [AW-1:0] idx_q;
  logic [AW:0]   len_q;
  logic [7:0]    exp_q;

  logic          ld, ld_w;
  logic [7:0]    ld_reg;
  logic [31:0]   ld_dat;
  logic          fin, fin_err, idx_inc, idx_clr, cap_exp, clr_v;
  logic          rsp_hit, rsp_ok, waiting, last, len_zero;
  logic          v_over, v_diff, v_abort, v_chk;
  logic [CW-1:0] v_count;

  assign rsp_hit  = rsp_valid_i && req_valid_o;
  assign rsp_ok   = rsp_hit && !rsp_err_i;
  assign last     = ({1'b0, idx_q} == (len_q - 1'b1));
  assign len_zero = (len_q == '0);
  assign waiting  = (state == S_HALT) || (state == S_PTR_A) || (state == S_WDATA) ||
                    (state == S_PTR_B) || (state == S_RDATA) || (state == S_RUN);
  assign v_chk    = (state == S_RDATA) && rsp_ok;

  always_comb begin
    nxt     = state;
    ld      = 1'b0;
    ld_w    = 1'b1;
    ld_reg  = PTR_REG;
    ld_dat  = '0;
    fin     = 1'b0;
    fin_err = 1'b0;
    idx_inc = 1'b0;
    idx_clr = 1'b0;
    cap_exp = 1'b0;
    clr_v   = 1'b0;
    unique case (state)
      S_IDLE: if (start_i) begin
        nxt = S_HALT; ld = 1'b1; ld_reg = CTRL_REG; ld_dat = HALT_PAT;
        idx_clr = 1'b1; clr_v = 1'b1;
      end
      S_HALT: if (rsp_ok) begin
        nxt = S_PTR_A; ld = 1'b1;
      end
      S_PTR_A: if (rsp_ok) begin
        if (len_zero) begin nxt = S_PTR_B; ld = 1'b1; end
        else nxt = S_WFETCH;
      end
      S_WFETCH: nxt = S_WLOAD;
      S_WLOAD: begin
        nxt = S_WDATA; ld = 1'b1; ld_reg = DATA_REG; ld_dat = {24'd0, rom_data_i};
      end
      S_WDATA: if (rsp_ok) begin
        if (last) begin nxt = S_PTR_B; ld = 1'b1; idx_clr = 1'b1; end
        else begin nxt = S_WFETCH; idx_inc = 1'b1; end
      end
      S_PTR_B: if (rsp_ok) begin
        if (len_zero) begin nxt = S_RUN; ld = 1'b1; ld_reg = CTRL_REG; ld_dat = RUN_PAT; end
        else nxt = S_RFETCH;
      end
      S_RFETCH: nxt = S_RLOAD;
      S_RLOAD: begin
        nxt = S_RDATA; ld = 1'b1; ld_w = 1'b0; ld_reg = DATA_REG; cap_exp = 1'b1;
      end
      S_RDATA: if (rsp_ok) begin
        if (v_over || v_abort) begin
          fin = 1'b1; fin_err = 1'b1;
        end else if (last) begin
          if ((v_count != '0) || v_diff) begin fin = 1'b1; fin_err = 1'b1; end
          else begin nxt = S_RUN; ld = 1'b1; ld_reg = CTRL_REG; ld_dat = RUN_PAT; end
        end else begin
          nxt = S_RFETCH; idx_inc = 1'b1;
        end
      end
      S_RUN: if (rsp_ok) fin = 1'b1;
      default: nxt = S_IDLE;
    endcase
    if (waiting && rsp_hit && rsp_err_i) begin
      fin = 1'b1; fin_err = 1'b1; ld = 1'b0;
    end
    if (fin) nxt = S_IDLE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= S_IDLE;
      idx_q   <= '0;
      len_q   <= '0;
      exp_q   <= '0;
      done_o  <= 1'b0;
      error_o <= 1'b0;
    end else begin
      state  <= nxt;
      done_o <= fin;
      if (state == S_IDLE && start_i) begin
        len_q   <= image_len_i;
        error_o <= 1'b0;
      end
      if (fin) error_o <= fin_err;
      if (idx_clr)      idx_q <= '0;
      else if (idx_inc) idx_q <= idx_q + 1'b1;
      if (cap_exp) exp_q <= rom_data_i;
    end
  end

  assign rom_addr_o  = idx_q;
  assign req_block_o = BLK;
  assign req_sub_o   = SUB;
  assign mismatch_o  = v_count;

  mcl_req_port #(.RW(8), .DW(32)) u_req (
    .clk(clk), .rst(rst), .load_i(ld), .write_i(ld_w), .reg_i(ld_reg), .wdata_i(ld_dat),
    .rsp_valid_i(rsp_valid_i), .valid_o(req_valid_o), .write_o(req_write_o),
    .reg_o(req_reg_o), .wdata_o(req_wdata_o)
  );

  mcl_verify #(.MM_LIMIT(MM_LIMIT), .DW(32)) u_ver (
    .clk(clk), .rst(rst), .clr_i(clr_v), .chk_i(v_chk), .rdata_i(rsp_rdata_i),
    .exp_i(exp_q), .over_o(v_over), .diff_o(v_diff), .abort_o(v_abort), .count_o(v_count)
  );
endmodule

// File: rtl/mcl_seq_chk.sv
module mcl_seq_chk #(
  parameter int         MM_LIMIT = 4,
  parameter logic [7:0] CTRL_REG = 8'h10,
  localparam int        CW       = $clog2(MM_LIMIT + 2)
) (
  input logic          clk,
  input logic          rst,
  input logic          req_valid_o,
  input logic          req_write_o,
  input logic [7:0]    req_reg_o,
  input logic [31:0]   req_wdata_o,
  input logic          rsp_valid_i,
  input logic          done_o,
  input logic          error_o,
  input logic [CW-1:0] mismatch_o
);
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    req_valid_o && !rsp_valid_i |=> req_valid_o && $stable(req_reg_o) && $stable(req_wdata_o) && $stable(req_write_o)); // R13
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o); // R11
  AST_QUIET_AT_END: assert property (@(posedge clk) disable iff (rst)
    done_o |-> !req_valid_o); // R10
  AST_MISMATCH_FAILS: assert property (@(posedge clk) disable iff (rst)
    done_o && (mismatch_o != '0) |-> error_o); // R8
  AST_COUNT_CAP: assert property (@(posedge clk) disable iff (rst)
    mismatch_o <= CW'(MM_LIMIT + 1)); // R7
  AST_CTRL_PATTERN: assert property (@(posedge clk) disable iff (rst)
    req_valid_o && req_write_o && (req_reg_o == CTRL_REG) |->
      (req_wdata_o == mcl_pkg::HALT_PAT) || (req_wdata_o == mcl_pkg::RUN_PAT)); // R2
endmodule

bind mcl_seq mcl_seq_chk #(.MM_LIMIT(MM_LIMIT), .CTRL_REG(CTRL_REG)) u_chk (
  .clk(clk), .rst(rst), .req_valid_o(req_valid_o), .req_write_o(req_write_o),
  .req_reg_o(req_reg_o), .req_wdata_o(req_wdata_o), .rsp_valid_i(rsp_valid_i),
  .done_o(done_o), .error_o(error_o), .mismatch_o(mismatch_o)
);

// File: tb/mcl_seq_test.sv
`timescale 1ns/1ps
module mcl_seq_test;
  localparam int AW = 10;
  localparam int WD = 20000;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start_i = 1'b0;
  logic [AW:0]   image_len_i = '0;
  logic [AW-1:0] rom_addr_o;
  logic [7:0]    rom_q = '0;
  logic          req_valid_o, req_write_o;
  logic [2:0]    req_block_o;
  logic [3:0]    req_sub_o;
  logic [7:0]    req_reg_o;
  logic [31:0]   req_wdata_o;
  logic          rsp_valid_i = 1'b0;
  logic          rsp_err_i = 1'b0;
  logic [31:0]   rsp_rdata_i = '0;
  logic          done_o, error_o;
  logic [2:0]    mismatch_o;

  always #4 clk = ~clk;

  mcl_seq uut (
    .clk(clk), .rst(rst), .start_i(start_i), .image_len_i(image_len_i),
    .rom_addr_o(rom_addr_o), .rom_data_i(rom_q), .req_valid_o(req_valid_o),
    .req_write_o(req_write_o), .req_block_o(req_block_o), .req_sub_o(req_sub_o),
    .req_reg_o(req_reg_o), .req_wdata_o(req_wdata_o), .rsp_valid_i(rsp_valid_i),
    .rsp_err_i(rsp_err_i), .rsp_rdata_i(rsp_rdata_i), .done_o(done_o),
    .error_o(error_o), .mismatch_o(mismatch_o)
  );

  logic [7:0]  img [0:(1<<AW)-1];
  logic [31:0] rdv [0:(1<<AW)-1];
  always @(posedge clk) rom_q <= img[rom_addr_o];

  int checks = 0;
  int fails  = 0;
  logic [40:0] expq [$];
  int          mmq  [$];
  bit          exp_err;
  int          exp_mm;
  int          k = 0, rd_idx = 0, wcnt = 0, err_at_g = -1;
  int          cyc = 0, fin_cyc = -10;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, expv);
    end
  endtask

  // Behavioural model: the expected request list and the outcome of one run
  task automatic build(input int len, input int err_at);
    int mm;
    expq.delete(); mmq.delete(); mm = 0; exp_err = 0;
    expq.push_back({1'b1, 8'h10, 32'h8C}); mmq.push_back(0);
    expq.push_back({1'b1, 8'h11, 32'h0});  mmq.push_back(0);
    for (int i = 0; i < len; i++) begin
      expq.push_back({1'b1, 8'h12, 24'h0, img[i]}); mmq.push_back(0);
    end
    expq.push_back({1'b1, 8'h11, 32'h0}); mmq.push_back(0);
    for (int i = 0; i < len; i++) begin
      expq.push_back({1'b0, 8'h12, 32'h0});
      if (rdv[i] > 32'hFF) begin exp_err = 1; mmq.push_back(mm); break; end
      if (rdv[i][7:0] != img[i]) mm++;
      mmq.push_back(mm);
      if (mm > 4) begin exp_err = 1; break; end
    end
    if (!exp_err) begin
      if (mm != 0) exp_err = 1;
      else begin expq.push_back({1'b1, 8'h10, 32'h10B}); mmq.push_back(mm); end
    end
    if (err_at >= 0 && err_at < expq.size()) begin
      while (expq.size() > err_at + 1) begin void'(expq.pop_back()); void'(mmq.pop_back()); end
      exp_err = 1;
    end
    exp_mm = mmq[mmq.size()-1];
  endtask

  // Responder plus per-cycle done comparison
  always @(negedge clk) begin
    cyc++;
    if (!rst && (done_o || cyc == fin_cyc + 1))
      chk(done_o === (cyc == fin_cyc + 1), "R11", "done timing", done_o, cyc == fin_cyc + 1);
    if (rsp_valid_i) begin
      rsp_valid_i = 1'b0; rsp_err_i = 1'b0; rsp_rdata_i = '0;
    end else if (!rst && req_valid_o) begin
      if (wcnt > 0) wcnt--;
      else begin
        if (k >= expq.size()) begin
          chk(1'b0, "R10", "unexpected request", {req_write_o, req_reg_o}, 0);
        end else begin
          logic [40:0] e;
          e = expq[k];
          chk(req_block_o == 3'd7 && req_sub_o == 4'd0, "R2", "block/subblock",
              {req_block_o, req_sub_o}, 8'h70);
          chk(req_write_o == e[40] && req_reg_o == e[39:32], "R4", $sformatf("request %0d kind/reg", k),
              {req_write_o, req_reg_o}, e[40:32]);
          if (e[40])
            chk(req_wdata_o == e[31:0], "R4", $sformatf("request %0d data", k), req_wdata_o, e[31:0]);
          if (k == expq.size() - 1) fin_cyc = cyc;
        end
        rsp_valid_i = 1'b1;
        rsp_err_i   = (k == err_at_g);
        if (!req_write_o) begin rsp_rdata_i = rdv[rd_idx]; rd_idx++; end
        k++;
        wcnt = k % 3;
      end
    end
  end

  task automatic run(input int len, input int err_at, input bit poke, input string tag);
    int n; bit got;
    build(len, err_at);
    k = 0; rd_idx = 0; wcnt = 0; err_at_g = err_at; image_len_i = (AW+1)'(len);
    @(negedge clk); start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
    n = 0; got = 0;
    while (!got && n < WD) begin
      @(negedge clk); n++;
      if (done_o) got = 1;
      start_i = (poke && n == 10);
    end
    start_i = 1'b0;
    chk(got, tag, "watchdog: done seen", got, 1);
    chk(error_o == exp_err, tag, "error flag", error_o, exp_err);
    chk(mismatch_o == exp_mm, tag, "mismatch count", mismatch_o, exp_mm);
    chk(k == expq.size(), tag, "request count", k, expq.size());
    @(negedge clk);
    chk(done_o == 1'b0 && req_valid_o == 1'b0, "R11", "done falls, no request", {done_o, req_valid_o}, 0);
    repeat (4) @(negedge clk);
    chk(k == expq.size(), "R10", "no request after end", k, expq.size());
  endtask

  task automatic fresh_image(input int len);
    for (int i = 0; i < len; i++) begin
      img[i] = 8'((i * 37 + 5) & 8'hFF);
      rdv[i] = {24'h0, img[i]};
    end
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    chk(done_o == 0 && error_o == 0 && req_valid_o == 0 && mismatch_o == 0, "R1", "reset state",
        {done_o, error_o, req_valid_o, mismatch_o}, 0);
    // R2 R3 R4 R5 R9 R13, with a start pulse mid-run (R11)
    fresh_image(6);   run(6, -1, 1'b1, "R9");
    fresh_image(1);   run(1, -1, 1'b0, "R5");
    // R12 empty image
    run(0, -1, 1'b0, "R12");
    // R8 two mismatches
    fresh_image(8);   rdv[2] = rdv[2] ^ 32'h1; rdv[6] = rdv[6] ^ 32'h80;
    run(8, -1, 1'b0, "R8");
    // R7 early abort after fifth mismatch
    fresh_image(8);   for (int i = 0; i < 7; i++) rdv[i] = rdv[i] ^ 32'h4;
    run(8, -1, 1'b0, "R7");
    // R6 out-of-range readback after one mismatch
    fresh_image(8);   rdv[1] = rdv[1] ^ 32'h10; rdv[3] = 32'h0000_0100 | rdv[3];
    run(8, -1, 1'b0, "R6");
    // R10 transport error on an image write, on a read, and on the run write
    fresh_image(5);   run(5, 4, 1'b0, "R10");
    fresh_image(5);   run(5, 9, 1'b0, "R10");
    fresh_image(5);   run(5, 13, 1'b0, "R10");
    // R3 recovery: a clean run after failures
    fresh_image(20);  run(20, -1, 1'b0, "R3");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(200000 * 8);
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule